// File: doc/BRIEF.md
# Single-Channel Peripheral Word Mover

This block is one channel of a transfer engine. It copies 32-bit words between a memory-side port and a peripheral-side port, in either direction. Software programs it through a small register port. It sets a memory pointer, a peripheral pointer, a length and a handful of mode bits, and then sets the enable bit. Each word is read from the source side and then written to the destination side. Both sides use a request/acknowledge handshake in which read data is valid in the acknowledge cycle.

Bursts can be paced by one of several peripheral request lines, or they can run back to back. A pass runs either once, or continuously from the same programmed pointers and length. Every finished pass raises an end-of-count flag, which software clears by writing a one to it. A level interrupt follows that flag through two enable bits. The status register reports the number of words still to move while a pass is running.

Top module: `pdma_channel`

## Requirements
- R1: After a synchronous reset, every register reads 0, neither side requests, and `irq` is low.
- R2: The length field is bits 15:2 of the control register (offset 0x00). A value N moves N+1 words, which is the byte count minus four. The memory word just past the buffer is not written.
- R3: Control bit 27 set means peripheral-to-memory; clear means memory-to-peripheral. Each word is read from the source side and then written unchanged to the destination side, in order. Only one side requests at a time.
- R4: The memory address starts at the pointer at offset 0x18 and rises by 4 per word. The peripheral address starts at the pointer at offset 0x10. It stays fixed there when bit 18 of the sequence register (offset 0x14) is set, and otherwise rises by 4 per word.
- R5: When control bit 26 (one-shot) is set, the enable bit (control bit 31) reads 0 after one pass, and no further request is made.
- R6: When bit 26 is clear, the channel restarts from the programmed pointers and length after each pass. It raises end-of-count on every pass, and the enable bit stays set.
- R7: The end-of-count flag is bit 30 of the status register (offset 0x04). It is set at the end of each pass. Writing 1 to that bit clears it, and writing 0 leaves it unchanged.
- R8: `irq` is high exactly when the end-of-count flag, control bit 30 and sequence bit 31 are all set.
- R9: With control bit 24 set, each burst waits for `dreq[sel]`, where `sel` is control bits 19:16. Other request lines do not start a burst.
- R10: The sequence register bits 26:24 set the burst size: code 2 gives 1 word, code 3 gives 4 words, code 4 gives 8 words, and any other code gives 1 word. `per_burst` shows this size.
- R11: While a pass is running, status bits 15:2 hold the words still to move, minus one. When the channel is idle they show the programmed length field.
- R12: Writing the enable bit to 0 during a pass stops it. After that write no further request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_addr` |
| mem_req | output | 1 | Memory-side request |
| mem_we | output | 1 | Memory-side write (1) or read (0) |
| mem_addr | output | AW | Memory-side byte address |
| mem_wdata | output | 32 | Memory-side write data |
| mem_ack | input | 1 | Memory-side acknowledge |
| mem_rdata | input | 32 | Memory-side read data, valid with `mem_ack` |
| per_req | output | 1 | Peripheral-side request |
| per_we | output | 1 | Peripheral-side write (1) or read (0) |
| per_addr | output | AW | Peripheral-side byte address |
| per_wdata | output | 32 | Peripheral-side write data |
| per_ack | input | 1 | Peripheral-side acknowledge |
| per_rdata | input | 32 | Peripheral-side read data, valid with `per_ack` |
| per_burst | output | 4 | Burst size in words |
| dreq | input | REQ_LINES | Peripheral request lines |
| irq | output | 1 | Level interrupt |

## Verification
A register write takes effect at the next edge, and read data appears one edge after the address is presented. The first request follows two edges after the enabling write. Each word then takes one read edge and one write edge, plus one pacing edge at the start of each burst. The end-of-count flag and `irq` rise one edge after the acknowledge of the final write. The bench drives everything on falling edges and samples outputs there. It waits for completion by polling `irq` within a bounded window rather than at one fixed cycle. Checks for stalls and stops wait well beyond the longest word time before they compare the peripheral logs.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_RD,
    ST_WR
  } eng_state_t;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_PPTR = 8'h10;
  localparam logic [7:0] OFS_SEQ  = 8'h14;
  localparam logic [7:0] OFS_MPTR = 8'h18;

  localparam int B_EN      = 31;
  localparam int B_IE_EOC  = 30;
  localparam int B_TO_MEM  = 27;
  localparam int B_ONCE    = 26;
  localparam int B_FLOW    = 24;
  localparam int B_SEL_LO  = 16;
  localparam int B_SEQ_IE  = 31;
  localparam int B_WRAP    = 18;
  localparam int B_BURST   = 24;
  localparam int B_EOC     = 30;
  localparam int CNT_W     = 14;
endpackage

// File: rtl/pdma_burst_dec.sv
module pdma_burst_dec (
  input  logic [2:0] code,
  output logic [3:0] words
);
  always_comb begin
    case (code)
      3'd2:    words = 4'd1;
      3'd3:    words = 4'd4;
      3'd4:    words = 4'd8;
      default: words = 4'd1;
    endcase
  end
endmodule

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int REG_AW = 5,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              pass_done,
  input  logic              busy,
  input  logic [CNT_W-1:0]  remain,
  output logic              en,
  output logic              ie_eoc,
  output logic              to_mem,
  output logic              once,
  output logic              flow,
  output logic [SEL_W-1:0]  sel,
  output logic [CNT_W-1:0]  wcount,
  output logic [AW-1:0]     per_ptr,
  output logic [AW-1:0]     mem_ptr,
  output logic              seq_ie,
  output logic              wrap,
  output logic [2:0]        burst_code,
  output logic              eoc,
  output logic              start
);
  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_STAT);
  localparam logic [REG_AW-1:0] A_PPTR = REG_AW'(OFS_PPTR);
  localparam logic [REG_AW-1:0] A_SEQ  = REG_AW'(OFS_SEQ);
  localparam logic [REG_AW-1:0] A_MPTR = REG_AW'(OFS_MPTR);

  logic wr_ctrl, wr_stat;
  logic [CNT_W-1:0] remain_view;
  logic unused_wdata;

  assign wr_ctrl = wr && (addr == A_CTRL);
  assign wr_stat = wr && (addr == A_STAT);
  assign remain_view = busy ? remain : wcount;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      en         <= 1'b0;
      ie_eoc     <= 1'b0;
      to_mem     <= 1'b0;
      once       <= 1'b0;
      flow       <= 1'b0;
      sel        <= '0;
      wcount     <= '0;
      per_ptr    <= '0;
      mem_ptr    <= '0;
      seq_ie     <= 1'b0;
      wrap       <= 1'b0;
      burst_code <= 3'd0;
      eoc        <= 1'b0;
      start      <= 1'b0;
    end else begin
      start <= 1'b0;
      if (pass_done && once) en <= 1'b0;
      if (pass_done) eoc <= 1'b1;
      else if (wr_stat && wdata[B_EOC]) eoc <= 1'b0;
      if (wr_ctrl) begin
        en     <= wdata[B_EN];
        ie_eoc <= wdata[B_IE_EOC];
        to_mem <= wdata[B_TO_MEM];
        once   <= wdata[B_ONCE];
        flow   <= wdata[B_FLOW];
        sel    <= wdata[B_SEL_LO +: SEL_W];
        wcount <= wdata[CNT_W+1:2];
        start  <= wdata[B_EN] && !en;
      end
      if (wr && addr == A_PPTR) per_ptr <= AW'(wdata);
      if (wr && addr == A_MPTR) mem_ptr <= AW'(wdata);
      if (wr && addr == A_SEQ) begin
        seq_ie     <= wdata[B_SEQ_IE];
        wrap       <= wdata[B_WRAP];
        burst_code <= wdata[B_BURST +: 3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_CTRL:  rdata <= {en, ie_eoc, 2'b00, to_mem, once, 1'b0, flow,
                           8'(sel), wcount, 2'b00};
        A_STAT:  rdata <= {1'b0, eoc, 14'd0, remain_view, 2'b00};
        A_PPTR:  rdata <= 32'(per_ptr);
        A_SEQ:   rdata <= {seq_ie, 4'd0, burst_code, 5'd0, wrap, 18'd0};
        A_MPTR:  rdata <= 32'(mem_ptr);
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
  import pdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int REQ_LINES = 16,
  parameter int SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 start,
  input  logic                 to_mem,
  input  logic                 once,
  input  logic                 flow,
  input  logic [SEL_W-1:0]     sel,
  input  logic [REQ_LINES-1:0] dreq,
  input  logic [CNT_W-1:0]     wcount,
  input  logic [AW-1:0]        per_ptr,
  input  logic [AW-1:0]        mem_ptr,
  input  logic                 wrap,
  input  logic [3:0]           burst_words,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic                 mem_ack,
  input  logic [31:0]          mem_rdata,
  output logic                 per_req,
  output logic                 per_we,
  output logic [AW-1:0]        per_addr,
  output logic [31:0]          per_wdata,
  input  logic                 per_ack,
  input  logic [31:0]          per_rdata,
  output logic                 pass_done,
  output logic                 busy,
  output logic [CNT_W-1:0]     remain
);
  eng_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       bcnt;
  logic [31:0]      xfer_data;
  logic             src_ack, dst_ack;
  logic [31:0]      src_rdata;
  logic             in_rd, in_wr;

  assign in_rd     = (state == ST_RD);
  assign in_wr     = (state == ST_WR);
  assign src_ack   = to_mem ? per_ack : mem_ack;
  assign dst_ack   = to_mem ? mem_ack : per_ack;
  assign src_rdata = to_mem ? per_rdata : mem_rdata;

  assign mem_req   = (in_rd && !to_mem) || (in_wr && to_mem);
  assign per_req   = (in_rd && to_mem) || (in_wr && !to_mem);
  assign mem_we    = in_wr;
  assign per_we    = in_wr;
  assign mem_wdata = xfer_data;
  assign per_wdata = xfer_data;
  assign busy      = (state != ST_IDLE);
  assign remain    = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bcnt      <= 3'd0;
      xfer_data <= '0;
      mem_addr  <= '0;
      per_addr  <= '0;
      pass_done <= 1'b0;
    end else begin
      pass_done <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (start) begin
              cnt      <= wcount;
              mem_addr <= mem_ptr;
              per_addr <= per_ptr;
              state    <= ST_ARM;
            end
          end
          ST_ARM: begin
            if (!flow || dreq[sel]) begin
              bcnt  <= 3'(burst_words - 4'd1);
              state <= ST_RD;
            end
          end
          ST_RD: begin
            if (src_ack) begin
              xfer_data <= src_rdata;
              state     <= ST_WR;
            end
          end
          ST_WR: begin
            if (dst_ack) begin
              mem_addr <= mem_addr + AW'(4);
              if (!wrap) per_addr <= per_addr + AW'(4);
              if (cnt == '0) begin
                pass_done <= 1'b1;
                if (once) begin
                  state <= ST_IDLE;
                end else begin
                  cnt      <= wcount;
                  mem_addr <= mem_ptr;
                  per_addr <= per_ptr;
                  state    <= ST_ARM;
                end
              end else begin
                cnt <= cnt - CNT_W'(1);
                if (bcnt == 3'd0) begin
                  state <= ST_ARM;
                end else begin
                  bcnt  <= bcnt - 3'd1;
                  state <= ST_RD;
                end
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int REG_AW    = 5,
  parameter int REQ_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic                 mem_ack,
  input  logic [31:0]          mem_rdata,
  output logic                 per_req,
  output logic                 per_we,
  output logic [AW-1:0]        per_addr,
  output logic [31:0]          per_wdata,
  input  logic                 per_ack,
  input  logic [31:0]          per_rdata,
  output logic [3:0]           per_burst,
  input  logic [REQ_LINES-1:0] dreq,
  output logic                 irq
);
  localparam int SEL_W = $clog2(REQ_LINES);

  logic             ctrl_en, ie_eoc, to_mem, once, flow, seq_ie, wrap, eoc, start;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] wcount, remain;
  logic [AW-1:0]    per_ptr, mem_ptr;
  logic [2:0]       burst_code;
  logic [3:0]       burst_words;
  logic             pass_done, busy;

  pdma_burst_dec u_bdec (
    .code  (burst_code),
    .words (burst_words)
  );

  pdma_regs #(.AW(AW), .REG_AW(REG_AW), .SEL_W(SEL_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .pass_done  (pass_done),
    .busy       (busy),
    .remain     (remain),
    .en         (ctrl_en),
    .ie_eoc     (ie_eoc),
    .to_mem     (to_mem),
    .once       (once),
    .flow       (flow),
    .sel        (sel),
    .wcount     (wcount),
    .per_ptr    (per_ptr),
    .mem_ptr    (mem_ptr),
    .seq_ie     (seq_ie),
    .wrap       (wrap),
    .burst_code (burst_code),
    .eoc        (eoc),
    .start      (start)
  );

  pdma_engine #(.AW(AW), .REQ_LINES(REQ_LINES), .SEL_W(SEL_W)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .en          (ctrl_en),
    .start       (start),
    .to_mem      (to_mem),
    .once        (once),
    .flow        (flow),
    .sel         (sel),
    .dreq        (dreq),
    .wcount      (wcount),
    .per_ptr     (per_ptr),
    .mem_ptr     (mem_ptr),
    .wrap        (wrap),
    .burst_words (burst_words),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .per_req     (per_req),
    .per_we      (per_we),
    .per_addr    (per_addr),
    .per_wdata   (per_wdata),
    .per_ack     (per_ack),
    .per_rdata   (per_rdata),
    .pass_done   (pass_done),
    .busy        (busy),
    .remain      (remain)
  );

  assign per_burst = burst_words;
  assign irq       = eoc & ie_eoc & seq_ie;
endmodule

// File: rtl/pdma_channel_chk.sv
module pdma_channel_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          per_req,
  input logic          irq,
  input logic          eoc,
  input logic          en,
  input logic          ie_eoc,
  input logic          seq_ie,
  input logic          pass_done,
  input logic          busy,
  input logic          wrap,
  input logic [AW-1:0] per_addr,
  input logic [AW-1:0] per_ptr,
  input logic [13:0]   remain,
  input logic [13:0]   wcount
);
  // R3
  side_mutex_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && per_req));

  // R7
  eoc_after_pass_chk: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> eoc);

  // R8
  irq_after_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_done && ie_eoc && seq_ie) |=> irq);

  // R12
  stop_after_disable_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(en) |=> (!mem_req && !per_req));

  // R4
  wrap_fixed_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (per_req && wrap) |-> (per_addr == per_ptr));

  // R11
  remain_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && en) |-> (remain <= wcount));
endmodule

bind pdma_channel pdma_channel_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .per_req   (per_req),
  .irq       (irq),
  .eoc       (eoc),
  .en        (ctrl_en),
  .ie_eoc    (ie_eoc),
  .seq_ie    (seq_ie),
  .pass_done (pass_done),
  .busy      (busy),
  .wrap      (wrap),
  .per_addr  (per_addr),
  .per_ptr   (per_ptr),
  .remain    (remain),
  .wcount    (wcount)
);

// File: tb/pdma_channel_tb_top.sv
module pdma_channel_tb_top;
  localparam int AW = 32;
  localparam int REG_AW = 5;
  localparam int REQ_LINES = 16;

  // vector: {to_mem, wrap, burst code[2:0], words-1[5:0]}
  localparam logic [10:0] VEC [0:5] = '{
    {1'b0, 1'b1, 3'd2, 6'd3},
    {1'b0, 1'b0, 3'd3, 6'd7},
    {1'b1, 1'b1, 3'd4, 6'd4},
    {1'b1, 1'b0, 3'd2, 6'd0},
    {1'b0, 1'b1, 3'd4, 6'd15},
    {1'b1, 1'b1, 3'd3, 6'd8}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic mem_req, mem_we, mem_ack, per_req, per_we, per_ack, irq;
  logic [AW-1:0] mem_addr, per_addr;
  logic [31:0] mem_wdata, mem_rdata, per_wdata, per_rdata;
  logic [3:0] per_burst;
  logic [REQ_LINES-1:0] dreq = '0;
  logic tb_clr = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] mem_arr [0:63];
  logic [31:0] pw_data [0:63];
  logic [31:0] pw_addr [0:63];
  logic [31:0] pr_addr [0:63];
  int per_wr_cnt, per_rd_cnt;

  always #4 clk = ~clk;

  pdma_channel #(.AW(AW), .REG_AW(REG_AW), .REQ_LINES(REQ_LINES)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr),
    .per_wdata(per_wdata), .per_ack(per_ack), .per_rdata(per_rdata),
    .per_burst(per_burst), .dreq(dreq), .irq(irq)
  );

  assign mem_ack   = mem_req;
  assign per_ack   = per_req;
  assign mem_rdata = mem_arr[mem_addr[7:2]];
  assign per_rdata = {16'hC0DE, per_rd_cnt[15:0]};

  always @(posedge clk) begin
    if (rst || tb_clr) begin
      for (int i = 0; i < 64; i++) begin
        mem_arr[i] <= 32'h1000_0000 + 32'(i);
        pw_data[i] <= '0;
        pw_addr[i] <= '0;
        pr_addr[i] <= '0;
      end
      per_wr_cnt <= 0;
      per_rd_cnt <= 0;
    end else begin
      if (mem_req && mem_we) mem_arr[mem_addr[7:2]] <= mem_wdata;
      if (per_req && per_we) begin
        pw_data[per_wr_cnt[5:0]] <= per_wdata;
        pw_addr[per_wr_cnt[5:0]] <= per_addr;
        per_wr_cnt <= per_wr_cnt + 1;
      end
      if (per_req && !per_we) begin
        pr_addr[per_rd_cnt[5:0]] <= per_addr;
        per_rd_cnt <= per_rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = REG_AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    reg_addr = REG_AW'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_irq(input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (irq) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic clear_bench();
    tb_clr = 1'b1;
    @(negedge clk);
    tb_clr = 1'b0;
  endtask

  function automatic logic [3:0] exp_burst(input logic [2:0] c);
    case (c)
      3'd3: return 4'd4;
      3'd4: return 4'd8;
      default: return 4'd1;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit ok;
    int snap;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd_reg(8'h00, d); chk("R1 ctrl", d, 32'h0);
    rd_reg(8'h04, d); chk("R1 stat", d, 32'h0);
    rd_reg(8'h10, d); chk("R1 pptr", d, 32'h0);
    rd_reg(8'h14, d); chk("R1 seq", d, 32'h0);
    chk("R1 irq/req", {29'd0, irq, mem_req, per_req}, 32'h0);

    // table of one-shot passes
    for (int v = 0; v < 6; v++) begin
      logic tm, wp;
      logic [2:0] bc;
      int nw;
      tm = VEC[v][10]; wp = VEC[v][9]; bc = VEC[v][8:6]; nw = int'(VEC[v][5:0]) + 1;
      clear_bench();
      wr_reg(8'h10, 32'h40);
      wr_reg(8'h18, 32'h0);
      wr_reg(8'h14, 32'h8000_0000 | (32'(bc) << 24) | (32'(wp) << 18));
      wr_reg(8'h04, 32'h4000_0000);
      chk("R10 per_burst", {28'd0, per_burst}, {28'd0, exp_burst(bc)});
      wr_reg(8'h00, 32'hC400_0000 | (32'(tm) << 27) | (32'(VEC[v][5:0]) << 2));
      wait_irq(400, ok);
      chk("R7 R8 irq at pass end", {31'd0, ok}, 32'd1);
      rd_reg(8'h04, d); chk("R7 eoc flag", {31'd0, d[30]}, 32'd1);
      rd_reg(8'h00, d); chk("R5 enable cleared", {31'd0, d[31]}, 32'd0);
      if (!tm) begin
        chk("R2 word count", 32'(per_wr_cnt), 32'(nw));
        for (int k = 0; k < nw; k++)
          chk("R3 mem to per data", pw_data[k], 32'h1000_0000 + 32'(k));
        chk("R4 per addr", pw_addr[nw-1], 32'h40 + (wp ? 32'h0 : 32'(4*(nw-1))));
      end else begin
        chk("R2 word count", 32'(per_rd_cnt), 32'(nw));
        for (int k = 0; k < nw; k++)
          chk("R3 R4 per to mem data", mem_arr[k], 32'hC0DE_0000 + 32'(k));
        chk("R2 past end untouched", mem_arr[nw], 32'h1000_0000 + 32'(nw));
        chk("R4 per addr", pr_addr[nw-1], 32'h40 + (wp ? 32'h0 : 32'(4*(nw-1))));
      end
    end

    // R8 gating by sequence interrupt enable, R7 write-zero has no effect
    wr_reg(8'h14, 32'h0300_0000);
    chk("R8 irq off by seq ie", {31'd0, irq}, 32'd0);
    wr_reg(8'h14, 32'h8300_0000);
    chk("R8 irq back on", {31'd0, irq}, 32'd1);
    wr_reg(8'h04, 32'h0);
    rd_reg(8'h04, d); chk("R7 write zero keeps eoc", {31'd0, d[30]}, 32'd1);
    wr_reg(8'h04, 32'h4000_0000);
    rd_reg(8'h04, d); chk("R7 w1c clears eoc", {31'd0, d[30]}, 32'd0);
    chk("R8 irq low after clear", {31'd0, irq}, 32'd0);

    // R9 R10 R11 flow control, sel 5, 8 words, burst 4
    clear_bench();
    wr_reg(8'h10, 32'h40);
    wr_reg(8'h18, 32'h0);
    wr_reg(8'h14, 32'h8300_0000);
    wr_reg(8'h00, 32'hC500_0000 | (32'd5 << 16) | (32'd7 << 2));
    repeat (20) @(negedge clk);
    chk("R9 stall without dreq", 32'(per_wr_cnt), 32'd0);
    rd_reg(8'h04, d); chk("R11 remain before", 32'(d[15:2]), 32'd7);
    dreq[5] = 1'b1; @(negedge clk); dreq[5] = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 one burst of four", 32'(per_wr_cnt), 32'd4);
    chk("R10 per_burst", {28'd0, per_burst}, 32'd4);
    rd_reg(8'h04, d); chk("R11 remain live", 32'(d[15:2]), 32'd3);
    dreq[4] = 1'b1; @(negedge clk); dreq[4] = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9 other line ignored", 32'(per_wr_cnt), 32'd4);
    dreq[5] = 1'b1; @(negedge clk); dreq[5] = 1'b0;
    wait_irq(100, ok);
    chk("R9 second burst completes", {31'd0, ok}, 32'd1);
    chk("R9 total words", 32'(per_wr_cnt), 32'd8);
    chk("R3 last word", pw_data[7], 32'h1000_0007);
    wr_reg(8'h04, 32'h4000_0000);

    // R6 continuous mode, R12 stop
    clear_bench();
    wr_reg(8'h10, 32'h40);
    wr_reg(8'h18, 32'h0);
    wr_reg(8'h14, 32'h8200_0000);
    wr_reg(8'h00, 32'hC000_0000 | (32'd1 << 2));
    wait_irq(100, ok);
    chk("R6 first pass", {31'd0, ok}, 32'd1);
    wr_reg(8'h04, 32'h4000_0000);
    wait_irq(100, ok);
    chk("R6 second pass eoc", {31'd0, ok}, 32'd1);
    rd_reg(8'h00, d); chk("R6 enable stays", {31'd0, d[31]}, 32'd1);
    wr_reg(8'h00, 32'h0);
    chk("R6 restart addr", pw_addr[2], 32'h40);
    chk("R4 incr addr", pw_addr[1], 32'h44);
    chk("R6 restart data", pw_data[2], 32'h1000_0000);
    repeat (3) @(negedge clk);
    snap = per_wr_cnt;
    repeat (20) @(negedge clk);
    chk("R12 stopped", 32'(per_wr_cnt), 32'(snap));
    chk("R12 no request", {30'd0, mem_req, per_req}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule